// File: doc/BRIEF.md
# Atomic Word Memory with Arbitrated Read-Modify-Write

This block is a small shared word store placed in front of several requesters. Each requester has a valid/ready request channel carrying an address, an operand and an opcode. Each cycle the block accepts at most one request and completes it in full. Plain reads and writes are supported. So are three read-modify-write operations: set-to-one (test-and-set), swap with the operand (exchange), and add-one (fetch-and-increment). Each of these reads the addressed word and writes its replacement within the same clock edge. No other access can fall between the read and the write.

Every accepted request returns the word that the location held before the operation. The response is on a per-port valid strobe with a per-port data lane, one cycle after acceptance. A requester that needs a lock or a shared job counter gets it with one request and never needs a retry loop. A parameter selects how the ports share the store. The default is a rotating (round-robin) grant. A fixed lowest-index-wins variant is also available.

Top module: `amo_unit`

## Requirements
- R1: Reset clears every memory word to zero and drops every response valid. After reset the rotating priority starts at port 0.
- R2: At most one port sees its ready high in any cycle, and only a port whose valid is high. Every ready is low while reset is asserted, and a request offered during reset has no effect.
- R3: With rotating grant, the port that has priority is the one after the last granted port, wrapping after the highest index. Among the requesting ports, the first one found in that order from the priority port is granted. A cycle with no grant leaves the priority unchanged.
- R4: A request accepted in cycle t raises response valid on that port only in cycle t+1. Its data lane carries the word the location held before the operation.
- R5: Opcode 3'b000 (read) leaves the location unchanged.
- R6: Opcode 3'b001 (write) stores the operand and returns the overwritten word.
- R7: Opcode 3'b010 (test-and-set) returns the old word and leaves the location holding 1.
- R8: Opcode 3'b011 (exchange) returns the old word and leaves the location holding the operand.
- R9: Opcode 3'b100 (fetch-and-increment) returns the old word and stores it plus one, wrapping to zero from all ones.
- R10: Opcodes 3'b101 to 3'b111 act as a read and leave the location unchanged.
- R11: Operations accepted in consecutive cycles on the same address are performed strictly one after the other. The second one sees the complete result of the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | NPORTS | Request valid, one bit per port |
| req_ready | output | NPORTS | Request accepted this cycle, one bit per port |
| req_op | input | 3*NPORTS | Opcode per port, port i in bits [3i+2:3i] |
| req_addr | input | AW*NPORTS | Word address per port |
| req_data | input | DW*NPORTS | Operand per port |
| rsp_valid | output | NPORTS | Response strobe per port |
| rsp_data | output | DW*NPORTS | Old memory word per port, meaningful while rsp_valid is high |

## Verification
The hardest case to reach is several ports asking for the same atomic update of the same word in one cycle. The interleaving that would cause a lost update can only happen in that case. The stimulus holds all four ports valid with fetch-and-increment on one address. Each granted port drops its request, and the others keep waiting. The bench then expects the grant to rotate one port per cycle from the current priority, and the returned counts to rise 0, 1, 2, 3 in grant order. A later reset while requests are pending shows that the priority returns to port 0.

// File: rtl/amo_pkg.sv
package amo_pkg;
   typedef enum logic [2:0] {
      OP_READ  = 3'b000,
      OP_WRITE = 3'b001,
      OP_TAS   = 3'b010,
      OP_XCHG  = 3'b011,
      OP_FINC  = 3'b100
   } amo_op_e;

   localparam int unsigned OPW = 3;
endpackage

// File: rtl/amo_arbiter.sv
module amo_arbiter #(
   parameter int unsigned NPORTS = 4,
   parameter bit          ROTATE = 1'b1,
   localparam int unsigned IW    = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NPORTS-1:0] req,
   output logic [NPORTS-1:0] grant,
   output logic [IW-1:0]     grant_idx,
   output logic              grant_any
);
   logic [IW-1:0] prio;

   always_comb begin
      grant     = '0;
      grant_idx = '0;
      grant_any = 1'b0;
      for (int k = 0; k < int'(NPORTS); k++) begin
         int cand;
         cand = (int'(prio) + k) % int'(NPORTS);
         if (!grant_any && req[cand]) begin
            grant_any   = 1'b1;
            grant_idx   = IW'(cand);
            grant[cand] = 1'b1;
         end
      end
   end

   generate
      if (ROTATE) begin : g_rotate
         always_ff @(posedge clk) begin
            if (rst)
               prio <= '0;
            else if (grant_any)
               prio <= (grant_idx == IW'(NPORTS - 1)) ? '0 : grant_idx + IW'(1);
         end
      end else begin : g_fixed
         assign prio = '0;
      end
   endgenerate
endmodule

// File: rtl/amo_alu.sv
module amo_alu
   import amo_pkg::*;
#(
   parameter int unsigned DW = 16
) (
   input  logic [OPW-1:0] op,
   input  logic [DW-1:0]  old_word,
   input  logic [DW-1:0]  operand,
   output logic           wr_en,
   output logic [DW-1:0]  new_word
);
   amo_op_e code;
   assign code = amo_op_e'(op);

   always_comb begin
      wr_en    = 1'b0;
      new_word = old_word;
      case (code)
         OP_WRITE, OP_XCHG: begin
            wr_en    = 1'b1;
            new_word = operand;
         end
         OP_TAS: begin
            wr_en    = 1'b1;
            new_word = DW'(1);
         end
         OP_FINC: begin
            wr_en    = 1'b1;
            new_word = old_word + DW'(1);
         end
         default: begin
            wr_en    = 1'b0;
            new_word = old_word;
         end
      endcase
   end
endmodule

// File: rtl/amo_store.sv
module amo_store #(
   parameter int unsigned AW = 4,
   parameter int unsigned DW = 16,
   localparam int unsigned DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] addr,
   output logic [DW-1:0] rd_word,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_word
);
   logic [DW-1:0] mem [DEPTH];

   assign rd_word = mem[addr];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[addr] <= wr_word;
      end
   end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
   import amo_pkg::*;
#(
   parameter int unsigned NPORTS = 4,
   parameter int unsigned AW     = 4,
   parameter int unsigned DW     = 16,
   parameter bit          ROTATE = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [NPORTS-1:0]     req_valid,
   output logic [NPORTS-1:0]     req_ready,
   input  logic [OPW*NPORTS-1:0] req_op,
   input  logic [AW*NPORTS-1:0]  req_addr,
   input  logic [DW*NPORTS-1:0]  req_data,
   output logic [NPORTS-1:0]     rsp_valid,
   output logic [DW*NPORTS-1:0]  rsp_data
);
   localparam int unsigned IW = (NPORTS > 1) ? $clog2(NPORTS) : 1;

   generate
      if (NPORTS < 2)   begin : g_chk_ports $error("amo_unit: NPORTS must be at least 2"); end
      if (AW < 1 || AW > 10) begin : g_chk_aw $error("amo_unit: AW out of range 1..10"); end
      if (DW < 2)       begin : g_chk_dw    $error("amo_unit: DW must be at least 2"); end
   endgenerate

   logic [NPORTS-1:0] grant;
   logic [IW-1:0]     sel;
   logic              any;
   logic [NPORTS-1:0] accept;
   logic [OPW-1:0]    sel_op;
   logic [AW-1:0]     sel_addr;
   logic [DW-1:0]     sel_data;
   logic [DW-1:0]     old_word;
   logic [DW-1:0]     new_word;
   logic              alu_wr;

   amo_arbiter #(.NPORTS(NPORTS), .ROTATE(ROTATE)) u_arb (
      .clk       (clk),
      .rst       (rst),
      .req       (req_valid & {NPORTS{~rst}}),
      .grant     (grant),
      .grant_idx (sel),
      .grant_any (any)
   );

   assign accept    = grant;
   assign req_ready = grant;
   assign sel_op    = req_op[sel*OPW +: OPW];
   assign sel_addr  = req_addr[sel*AW +: AW];
   assign sel_data  = req_data[sel*DW +: DW];

   amo_store #(.AW(AW), .DW(DW)) u_mem (
      .clk     (clk),
      .rst     (rst),
      .addr    (sel_addr),
      .rd_word (old_word),
      .wr_en   (alu_wr & any),
      .wr_word (new_word)
   );

   amo_alu #(.DW(DW)) u_alu (
      .op       (sel_op),
      .old_word (old_word),
      .operand  (sel_data),
      .wr_en    (alu_wr),
      .new_word (new_word)
   );

   generate
      for (genvar p = 0; p < int'(NPORTS); p++) begin : g_lane
         always_ff @(posedge clk) begin
            if (rst) begin
               rsp_valid[p]           <= 1'b0;
               rsp_data[p*DW +: DW]   <= '0;
            end else begin
               rsp_valid[p] <= accept[p];
               if (accept[p]) rsp_data[p*DW +: DW] <= old_word;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/amo_unit_sva.sv
module amo_unit_sva
   import amo_pkg::*;
#(
   parameter int unsigned NPORTS = 4,
   parameter int unsigned AW     = 4,
   parameter int unsigned DW     = 16
) (
   input logic                  clk,
   input logic                  rst,
   input logic [NPORTS-1:0]     req_valid,
   input logic [NPORTS-1:0]     req_ready,
   input logic [OPW*NPORTS-1:0] req_op,
   input logic [AW*NPORTS-1:0]  req_addr,
   input logic [DW*NPORTS-1:0]  req_data,
   input logic [NPORTS-1:0]     rsp_valid,
   input logic [DW*NPORTS-1:0]  rsp_data
);
   logic           acc_now;
   logic [OPW-1:0] op_now;
   logic [AW-1:0]  addr_now;
   logic [DW-1:0]  data_now;
   logic [DW-1:0]  rsp_word;
   logic           acc_q;
   logic [OPW-1:0] op_q;
   logic [AW-1:0]  addr_q;
   logic [DW-1:0]  data_q;
   logic           same_addr;

   always_comb begin
      acc_now  = 1'b0;
      op_now   = '0;
      addr_now = '0;
      data_now = '0;
      rsp_word = '0;
      for (int p = 0; p < int'(NPORTS); p++) begin
         if (req_valid[p] && req_ready[p]) begin
            acc_now  = 1'b1;
            op_now   = req_op[p*OPW +: OPW];
            addr_now = req_addr[p*AW +: AW];
            data_now = req_data[p*DW +: DW];
         end
         if (rsp_valid[p]) rsp_word = rsp_word | rsp_data[p*DW +: DW];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q  <= 1'b0;
         op_q   <= '0;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         acc_q  <= acc_now;
         op_q   <= op_now;
         addr_q <= addr_now;
         data_q <= data_now;
      end
   end

   assign same_addr = acc_q && acc_now && (addr_now == addr_q);

   a_r2_single_ready: assert property (@(posedge clk) disable iff (rst)
      $onehot0(req_ready));
   a_r2_ready_needs_valid: assert property (@(posedge clk) disable iff (rst)
      (req_ready & ~req_valid) == '0);
   a_r4_rsp_after_accept: assert property (@(posedge clk) disable iff (rst)
      rsp_valid == $past(req_valid & req_ready));
   a_r7_tas_then_one: assert property (@(posedge clk) disable iff (rst)
      (same_addr && op_q == OP_TAS) |=> rsp_word == DW'(1));
   a_r8_xchg_then_operand: assert property (@(posedge clk) disable iff (rst)
      (same_addr && op_q == OP_XCHG) |=> rsp_word == $past(data_q));
   a_r6_write_then_operand: assert property (@(posedge clk) disable iff (rst)
      (same_addr && op_q == OP_WRITE) |=> rsp_word == $past(data_q));
   a_r9_finc_then_plus_one: assert property (@(posedge clk) disable iff (rst)
      (same_addr && op_q == OP_FINC) |=> rsp_word == DW'($past(rsp_word) + DW'(1)));
   a_r5_read_then_same: assert property (@(posedge clk) disable iff (rst)
      (same_addr && op_q == OP_READ) |=> rsp_word == $past(rsp_word));
endmodule

bind amo_unit amo_unit_sva #(.NPORTS(NPORTS), .AW(AW), .DW(DW)) u_amo_unit_sva (
   .clk       (clk),
   .rst       (rst),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_op    (req_op),
   .req_addr  (req_addr),
   .req_data  (req_data),
   .rsp_valid (rsp_valid),
   .rsp_data  (rsp_data)
);

// File: tb/amo_unit_bench.sv
module amo_unit_bench;
   localparam int NP = 4;
   localparam int AW = 4;
   localparam int DW = 16;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [NP-1:0]     req_valid = '0;
   logic [NP-1:0]     req_ready;
   logic [3*NP-1:0]   req_op = '0;
   logic [AW*NP-1:0]  req_addr = '0;
   logic [DW*NP-1:0]  req_data = '0;
   logic [NP-1:0]     rsp_valid;
   logic [DW*NP-1:0]  rsp_data;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   amo_unit #(.NPORTS(NP), .AW(AW), .DW(DW)) u_amo_unit (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data)
   );

   // {port[40:39], op[38:36], addr[35:32], operand[31:16], expected old[15:0]}
   localparam logic [40:0] VEC [13] = '{
      {2'd0, 3'd1, 4'd3, 16'h1234, 16'h0000},  // R6 write
      {2'd1, 3'd0, 4'd3, 16'h0000, 16'h1234},  // R5 read
      {2'd2, 3'd2, 4'd5, 16'h0000, 16'h0000},  // R7 tas on zero
      {2'd3, 3'd2, 4'd5, 16'h0000, 16'h0001},  // R7 tas on one
      {2'd0, 3'd3, 4'd3, 16'hBEEF, 16'h1234},  // R8 exchange
      {2'd1, 3'd0, 4'd3, 16'h7777, 16'hBEEF},  // R5 read ignores operand
      {2'd2, 3'd4, 4'd7, 16'h0000, 16'h0000},  // R9
      {2'd2, 3'd4, 4'd7, 16'h0000, 16'h0001},  // R9
      {2'd3, 3'd1, 4'd7, 16'hFFFF, 16'h0002},  // R6
      {2'd0, 3'd4, 4'd7, 16'h0000, 16'hFFFF},  // R9 wrap
      {2'd1, 3'd0, 4'd7, 16'h0000, 16'h0000},  // R9 wrapped to zero
      {2'd3, 3'd6, 4'd3, 16'h5555, 16'hBEEF},  // R10 undefined code
      {2'd0, 3'd0, 4'd3, 16'h0000, 16'hBEEF}   // R10 location unchanged
   };

   function automatic string op_tag(input logic [2:0] op);
      case (op)
         3'd0: return "R5";
         3'd1: return "R6";
         3'd2: return "R7";
         3'd3: return "R8";
         3'd4: return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic set_port(input int p, input logic [2:0] op, input logic [AW-1:0] a,
                           input logic [DW-1:0] d);
      req_valid[p]          = 1'b1;
      req_op[p*3 +: 3]      = op;
      req_addr[p*AW +: AW]  = a;
      req_data[p*DW +: DW]  = d;
   endtask

   // one request on one port; checks grant, then the response one cycle later (R4)
   task automatic do_op(input int p, input logic [2:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [DW-1:0] exp, input string tag);
      @(negedge clk);
      req_valid = '0;
      set_port(p, op, a, d);
      #1;
      chk({tag, " R2 ready"}, 32'(req_ready), 32'(1 << p));
      @(negedge clk);
      req_valid = '0;
      chk({tag, " R4 rsp_valid"}, 32'(rsp_valid), 32'(1 << p));
      chk({tag, " old word"}, 32'(rsp_data[p*DW +: DW]), 32'(exp));
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=<20000", cycles);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R2: request offered during reset is ignored
      @(negedge clk);
      set_port(0, 3'd1, 4'd9, 16'hAAAA);
      #1;
      chk("R2 ready low in reset", 32'(req_ready), 32'd0);
      repeat (2) @(negedge clk);
      chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
      req_valid = '0;
      rst = 1'b0;
      do_op(1, 3'd0, 4'd9, 16'h0000, 16'h0000, "R1 memory zero");

      for (int i = 0; i < 13; i++) begin
         logic [40:0] v;
         v = VEC[i];
         do_op(int'(v[40:39]), v[38:36], v[35:32], v[31:16], v[15:0], op_tag(v[38:36]));
      end

      // R3 / R11: all ports fetch-and-increment address 10 together; last grant was port 0
      @(negedge clk);
      for (int p = 0; p < NP; p++) set_port(p, 3'd4, 4'd10, 16'h0000);
      for (int k = 0; k < NP; k++) begin
         int g;
         g = (1 + k) % NP;
         #1;
         chk("R3 rotating grant", 32'(req_ready), 32'(1 << g));
         @(negedge clk);
         req_valid[g] = 1'b0;
         chk("R4 single response", 32'(rsp_valid), 32'(1 << g));
         chk("R11 serialized count", 32'(rsp_data[g*DW +: DW]), 32'(k));
      end
      req_valid = '0;
      do_op(2, 3'd0, 4'd10, 16'h0000, 16'h0004, "R11 final count");

      // R1: reset mid-run clears memory and priority
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      for (int p = 0; p < NP; p++) set_port(p, 3'd0, 4'd3, 16'h0000);
      #1;
      chk("R1 priority back at port 0", 32'(req_ready), 32'd1);
      @(negedge clk);
      req_valid = '0;
      chk("R1 memory cleared", 32'(rsp_data[DW-1:0]), 32'd0);
      // R3: idle cycles keep priority at port 1
      repeat (3) @(negedge clk);
      set_port(0, 3'd0, 4'd0, 16'h0000);
      set_port(1, 3'd0, 4'd0, 16'h0000);
      #1;
      chk("R3 priority held over idle", 32'(req_ready), 32'd2);
      @(negedge clk);
      req_valid = '0;

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule